// File: doc/BRIEF.md
# Slow-Oscillator Period Capture Timer

This block measures the period of a slow, uncalibrated on-chip oscillator against a trusted system clock. A free-running counter advances once per system clock cycle. The slow oscillator's output enters asynchronously and passes through a two-flop synchronizer followed by a rising-edge detector. While capture is enabled, each detected rising edge copies the running count into a capture register and raises a sticky capture flag. The block also keeps the previous capture and reports the difference between the two newest captures as the measured period, in system clock cycles.

The block also holds a small trim register whose value drives the oscillator's frequency control. A lower trim code makes the oscillator faster and a higher code makes it slower. The reset value of the trim register is a parameter, so each device can start from its own calibrated setting. Software or a controller outside this block reads the period, writes the trim and repeats, which closes the calibration loop. All outputs are plain level registers. No output carries a handshake, and a reader may sample the outputs at any time without back-pressure.

Top module: `lfo_period_capture`

## Requirements
- R1: After reset, the timer, the capture value, the period and the period-valid flag are zero, the capture flag is clear, and the trim output equals the TRIM_RESET parameter.
- R2: The timer increases by one every system clock cycle and wraps modulo 2^CNT_W.
- R3: A rising edge on the slow oscillator input is detected after a two-flop synchronizer. If capture is enabled, the timer value is stored as the capture value two clock edges after the first synchronizer flop samples the new high level.
- R4: While the capture enable is low, oscillator edges cause no capture. The capture value stays unchanged and the capture flag is not set.
- R5: A falling edge or a steady level on the oscillator input causes no capture. Each rising edge causes exactly one capture.
- R6: On each capture, the period output becomes (new capture − previous capture) modulo 2^CNT_W. The result is correct even when the timer wraps between the two captures.
- R7: The period-valid flag rises only once at least two captures have occurred since capture was enabled. It is cleared, together with the capture count, whenever the capture enable is low.
- R8: The capture flag is set by every capture and stays set until a clear strobe is given. If a capture and a clear occur in the same cycle, the capture wins.
- R9: A trim write strobe loads the 4-bit trim data into the trim register, which drives the trim output. Without a strobe, the trim register holds its value.
- R10: The capture value and the period hold their values between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trusted system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Enables capture on slow oscillator rising edges |
| lfo_in | input | 1 | Slow oscillator output (asynchronous) |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| trim_we | input | 1 | Trim register write strobe |
| trim_wdata | input | TRIM_W | Trim value to load |
| trim_out | output | TRIM_W | Oscillator frequency trim (lower code is faster) |
| timer_value | output | CNT_W | Running timer |
| cap_value | output | CNT_W | Most recent capture |
| period_value | output | CNT_W | Difference of the two most recent captures |
| period_valid | output | 1 | At least two captures since enable |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions check several properties on every cycle. The timer steps by one. The synchronized edge pulse lasts a single cycle. The capture value and trim hold their values when nothing changes them. The flag stays set until it is cleared. The period equals the new capture minus the old one, and validity drops while capture is disabled. Only the bench scenarios can show the rest. These are the exact capture latency through the synchronizer, that disabled or falling edges are ignored, correct periods across a timer wrap with uneven duty cycles, and the capture-beats-clear priority. The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/lfo_cap_pkg.sv
package lfo_cap_pkg;
  localparam int MAX_W = 32;

  // Modulo subtraction on the widest supported width; callers slice to their own width.
  function automatic logic [MAX_W-1:0] wrap_sub(input logic [MAX_W-1:0] a,
                                                input logic [MAX_W-1:0] b);
    return a - b;
  endfunction

  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_ONE  = 2'd1,
    CNT_TWO  = 2'd2
  } cap_count_e;
endpackage

// File: rtl/lfo_sync_edge.sv
module lfo_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lfo_free_counter.sv
module lfo_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + W'(1));
endmodule

// File: rtl/lfo_capture_unit.sv
module lfo_capture_unit
  import lfo_cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         evt,
  input  logic         clr,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_value,
  output logic [W-1:0] period,
  output logic         valid,
  output logic         flag
);
  cap_count_e ncap;
  logic [MAX_W-1:0] diff_wide;

  assign diff_wide = wrap_sub(MAX_W'(count), MAX_W'(cap_value));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_value <= '0;
      period    <= '0;
    end else if (evt) begin
      cap_value <= count;
      period    <= diff_wide[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)              ncap <= CNT_NONE;
    else if (evt && ncap == CNT_NONE) ncap <= CNT_ONE;
    else if (evt && ncap == CNT_ONE)  ncap <= CNT_TWO;
  end

  assign valid = (ncap == CNT_TWO);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(cap_value) && $stable(period)));
  assert_period_diff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> period == W'(cap_value - $past(cap_value)));
  assert_valid_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid);
endmodule

// File: rtl/lfo_trim_reg.sv
module lfo_trim_reg #(
  parameter int W     = 4,
  parameter int RST_V = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] trim
);
  always_ff @(posedge clk) begin
    if (!rst_n)  trim <= W'(RST_V);
    else if (we) trim <= wdata;
  end

  assert_trim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(trim));
endmodule

// File: rtl/lfo_period_capture.sv
module lfo_period_capture #(
  parameter int CNT_W      = 16,
  parameter int TRIM_W     = 4,
  parameter int TRIM_RESET = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              lfo_in,
  input  logic              flag_clr,
  input  logic              trim_we,
  input  logic [TRIM_W-1:0] trim_wdata,
  output logic [TRIM_W-1:0] trim_out,
  output logic [CNT_W-1:0]  timer_value,
  output logic [CNT_W-1:0]  cap_value,
  output logic [CNT_W-1:0]  period_value,
  output logic              period_valid,
  output logic              cap_flag
);
  logic lfo_rise;
  logic cap_evt;

  lfo_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(lfo_in), .rise(lfo_rise)
  );

  lfo_free_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count(timer_value)
  );

  assign cap_evt = lfo_rise & cap_en;

  lfo_capture_unit #(.W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(cap_en), .evt(cap_evt), .clr(flag_clr),
    .count(timer_value), .cap_value(cap_value), .period(period_value),
    .valid(period_valid), .flag(cap_flag)
  );

  lfo_trim_reg #(.W(TRIM_W), .RST_V(TRIM_RESET)) u_trim (
    .clk(clk), .rst_n(rst_n), .we(trim_we), .wdata(trim_wdata), .trim(trim_out)
  );

  assert_no_cap_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_value));
endmodule

// File: tb/tb_lfo_period_capture.sv
module tb_lfo_period_capture;
  localparam int CW = 12;
  localparam int TW = 4;
  localparam int TR = 11;
  localparam int MOD = 1 << CW;

  logic clk = 0, rst_n = 0, cap_en = 0, lfo_in = 0, flag_clr = 0, trim_we = 0;
  logic [TW-1:0] trim_wdata = '0;
  logic [TW-1:0] trim_out;
  logic [CW-1:0] timer_value, cap_value, period_value;
  logic period_valid, cap_flag;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  lfo_period_capture #(.CNT_W(CW), .TRIM_W(TW), .TRIM_RESET(TR)) dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .lfo_in(lfo_in), .flag_clr(flag_clr),
    .trim_we(trim_we), .trim_wdata(trim_wdata), .trim_out(trim_out),
    .timer_value(timer_value), .cap_value(cap_value), .period_value(period_value),
    .period_valid(period_valid), .cap_flag(cap_flag)
  );

  // Behavioural reference model
  int m_cnt, m_cap, m_per, m_n, m_trim;
  bit m_flag;
  bit m_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap = 0; m_per = 0; m_n = 0; m_flag = 0; m_trim = TR;
      m_hist = '{0, 0};
    end else begin
      bit cap;
      cap = m_hist[1] && !m_hist[0] && cap_en;   // [1]=second stage, [0]=older
      if (cap) begin
        m_per = (m_cnt - m_cap + MOD) % MOD;
        m_cap = m_cnt;
      end
      if (!cap_en) m_n = 0;
      else if (cap && m_n < 2) m_n++;
      if (cap) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (trim_we) m_trim = trim_wdata;
      m_cnt = (m_cnt + 1) % MOD;
      m_hist = '{m_hist[1], m_hist[2], lfo_in};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 timer", timer_value, m_cnt);
      chk("R3 R4 R5 R10 capture", cap_value, m_cap);
      chk("R6 R10 period", period_value, m_per);
      chk("R7 valid", period_valid, m_n >= 2);
      chk("R8 flag", cap_flag, m_flag);
      chk("R9 trim", trim_out, m_trim);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic osc(input int hi, input int lo, input int reps);
    for (int r = 0; r < reps; r++) begin
      lfo_in = 1; repeat (hi) @(negedge clk);
      lfo_in = 0; repeat (lo) @(negedge clk);
    end
  endtask

  initial begin
    m_hist = '{0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, observed one cycle after release (timer already 1)
    chk("R1 cap", cap_value, 0);
    chk("R1 period", period_value, 0);
    chk("R1 valid", period_valid, 0);
    chk("R1 flag", cap_flag, 0);
    chk("R1 trim", trim_out, TR);
    // R4: edges while disabled are ignored
    osc(5, 7, 6);
    chk("R4 no flag while disabled", cap_flag, 0);
    chk("R4 no capture while disabled", cap_value, 0);
    // Enable and run several duty patterns
    cap_en = 1;
    osc(20, 20, 4);
    chk("R7 valid after captures", period_valid, 1);
    chk("R6 period 40", period_value, 40);
    osc(3, 30, 4);
    osc(17, 9, 4);
    // R5: steady high level, no new capture
    lfo_in = 1; repeat (50) @(negedge clk);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    repeat (5) @(negedge clk);
    chk("R5 no capture on level", cap_flag, 0);
    lfo_in = 0; repeat (50) @(negedge clk);
    chk("R5 no capture on fall", cap_flag, 0);
    // R8: clear held during edges -> capture wins
    flag_clr = 1;
    osc(4, 4, 10);
    flag_clr = 0;
    // R7: disable drops valid, re-enable needs two captures
    cap_en = 0; @(negedge clk); @(negedge clk);
    chk("R7 valid cleared", period_valid, 0);
    cap_en = 1;
    osc(10, 10, 1);
    repeat (3) @(negedge clk);
    chk("R7 one capture not valid", period_valid, 0);
    // R9 trim writes
    trim_wdata = 4'h0; trim_we = 1; @(negedge clk); trim_we = 0;
    trim_wdata = 4'hF; repeat (3) @(negedge clk);
    chk("R9 trim loaded 0", trim_out, 0);
    trim_we = 1; @(negedge clk); trim_we = 0;
    // R6 long periods spanning timer wraps
    osc(700, 900, 8);
    chk("R6 wrapped period", period_value, 1600);
    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule